// File: doc/BRIEF.md
# Decode Legality Checker

This block sits at the opcode decode stage of a 32-bit processor. Each accepted cycle it takes the fetched instruction word, the current processor mode (master or slave) and three attributes looked up for the opcode: its addressing kind, a privileged flag and an exists flag. From these it either aborts the instruction with a trap request to a fixed vector, or issues it to execution. An issued instruction carries enables for indirection and indexing, an operand-size class, an effective reference address, and a flag marking references that fall inside the current general-register block.

The decision is held in a three-state machine that updates on the decode clock. `ST_IDLE` means no result. `ST_ISSUE` means an instruction is being passed on. `ST_TRAP` means an abort is being requested. When stall is low, every state moves as follows: to `ST_TRAP` when an accepted instruction breaks a rule, to `ST_ISSUE` when an accepted instruction is legal, and to `ST_IDLE` when nothing is presented. When stall is high, the state and every captured field stay as they are.

Top module: `ldc_top`

## Requirements
- R1: While reset is held, and at the first edge after reset, trap_valid and issue_valid are 0 and trap_vector is 0.
- R2: Field layout of instr: instr[31] is the indirect flag, instr[30:24] is the opcode, instr[19:17] is the index field, and instr[16:0] is the reference address. An instruction accepted with in_valid=1 and stall=0 gives its result one clock later, and opcode repeats instr[30:24] on issue.
- R3: The kind codes are 0 byte, 1 halfword, 2 word, 3 doubleword, 4 immediate operand and 5 immediate displacement. On issue, size_code is 0, 1, 2 or 3 for the byte, halfword, word and doubleword kinds, and 2 for both immediate kinds.
- R4: For the kinds 0 to 3, indirect_en equals instr[31] and index_en is 1 exactly when the index field is nonzero.
- R5: An immediate kind (4 or 5) that has instr[31]=1 raises trap_valid with trap_vector 0x40 and does not issue.
- R6: A legal immediate kind issues with index_en=0 and indirect_en=0, whatever the index field holds.
- R7: A privileged opcode in slave mode traps to 0x40. The same opcode in master mode issues.
- R8: An opcode with exists=0, or with a kind code of 6 or 7, traps to 0x40.
- R9: When several trap conditions hold at once, the block gives exactly one trap_valid pulse lasting one cycle, with issue_valid low and all issue flags 0.
- R10: For the doubleword kind, eff_addr has bit 0 forced to 0. For every other kind, eff_addr equals instr[16:0].
- R11: reg_sel is 1 on issue of a kind 0 to 3 whose eff_addr is below REG_COUNT (16). It is 0 for the immediate kinds.
- R12: While stall is 1, all outputs keep their values and the presented instruction is ignored.
- R13: A cycle with in_valid=0 and stall=0 leaves trap_valid and issue_valid at 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decode clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the current result |
| in_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Fetched instruction word |
| slave_mode | input | 1 | 1 = slave (user) mode |
| tbl_kind | input | 3 | Addressing kind from the decode table |
| tbl_priv | input | 1 | Opcode is privileged |
| tbl_exists | input | 1 | Opcode is implemented |
| trap_valid | output | 1 | Abort request pulse |
| trap_vector | output | 7 | Trap location, 0x40 while trapping |
| issue_valid | output | 1 | Instruction issues this cycle |
| opcode | output | 7 | Issued opcode |
| indirect_en | output | 1 | Indirect addressing enabled |
| index_en | output | 1 | Indexing enabled |
| size_code | output | 2 | Operand size class |
| eff_addr | output | 17 | Aligned reference address |
| reg_sel | output | 1 | Reference lies in the register block |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 7-bit vector of 0x40 and a 16-entry register block. This sets the reg_sel boundary between addresses 15 and 16 and places the doubleword alignment on bit 0 of a 17-bit address. With these values, every kind code from 0 to 7 can be reached, along with the edge addresses on both sides of the register block and every combination of trap conditions together with stall.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
    typedef enum logic [2:0] {
        AK_BYTE     = 3'd0,
        AK_HALF     = 3'd1,
        AK_WORD     = 3'd2,
        AK_DWORD    = 3'd3,
        AK_IMM_OP   = 3'd4,
        AK_IMM_DISP = 3'd5,
        AK_RSV6     = 3'd6,
        AK_RSV7     = 3'd7
    } addr_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_TRAP  = 2'd2
    } dec_state_e;
endpackage

// File: rtl/ldc_class.sv
module ldc_class
    import ldc_pkg::*;
(
    input  logic [2:0] kind_raw,
    output size_e      size,
    output logic       is_imm,
    output logic       is_indexed,
    output logic       is_dword,
    output logic       kind_ok
);
    always_comb begin
        size       = SZ_WORD;
        is_imm     = 1'b0;
        is_indexed = 1'b0;
        is_dword   = 1'b0;
        kind_ok    = 1'b1;
        unique case (addr_kind_e'(kind_raw))
            AK_BYTE:     begin size = SZ_BYTE;  is_indexed = 1'b1; end
            AK_HALF:     begin size = SZ_HALF;  is_indexed = 1'b1; end
            AK_WORD:     begin size = SZ_WORD;  is_indexed = 1'b1; end
            AK_DWORD:    begin size = SZ_DWORD; is_indexed = 1'b1; is_dword = 1'b1; end
            AK_IMM_OP:   is_imm = 1'b1;
            AK_IMM_DISP: is_imm = 1'b1;
            AK_RSV6:     kind_ok = 1'b0;
            AK_RSV7:     kind_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/ldc_fault.sv
module ldc_fault (
    input  logic ind_bit,
    input  logic is_imm,
    input  logic kind_ok,
    input  logic exists,
    input  logic priv,
    input  logic slave,
    output logic fault
);
    logic imm_indirect;
    logic priv_violation;
    logic missing;

    always_comb begin
        imm_indirect   = is_imm & ind_bit;
        priv_violation = priv & slave;
        missing        = ~exists | ~kind_ok;
        fault          = imm_indirect | priv_violation | missing;
    end
endmodule

// File: rtl/ldc_addr.sv
module ldc_addr #(
    parameter int ADDR_W    = 17,
    parameter int REG_COUNT = 16
) (
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic              is_dword,
    input  logic              is_indexed,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              reg_sel
);
    localparam logic [ADDR_W-1:0] REG_LIM = ADDR_W'(REG_COUNT);

    always_comb begin
        eff_addr    = ref_addr;
        eff_addr[0] = ref_addr[0] & ~is_dword;
        reg_sel     = is_indexed && (eff_addr < REG_LIM);
    end
endmodule

// File: rtl/ldc_top.sv
module ldc_top
    import ldc_pkg::*;
#(
    parameter int          INSTR_W   = 32,
    parameter int          VEC_W     = 7,
    parameter logic [6:0]  TRAP_VEC  = 7'h40,
    parameter int          REG_COUNT = 16,
    localparam int         ADDR_W    = INSTR_W - 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               slave_mode,
    input  logic [2:0]         tbl_kind,
    input  logic               tbl_priv,
    input  logic               tbl_exists,
    output logic               trap_valid,
    output logic [VEC_W-1:0]   trap_vector,
    output logic               issue_valid,
    output logic [6:0]         opcode,
    output logic               indirect_en,
    output logic               index_en,
    output logic [1:0]         size_code,
    output logic [ADDR_W-1:0]  eff_addr,
    output logic               reg_sel
);
    localparam int IND_BIT = INSTR_W - 1;
    localparam int OPC_HI  = INSTR_W - 2;
    localparam int OPC_LO  = INSTR_W - 8;
    localparam int IDX_HI  = INSTR_W - 13;
    localparam int IDX_LO  = INSTR_W - 15;

    size_e             c_size;
    logic              c_imm, c_indexed, c_dword, c_kind_ok, c_fault;
    logic [ADDR_W-1:0] c_eff;
    logic              c_rsel;

    ldc_class u_class (
        .kind_raw   (tbl_kind),
        .size       (c_size),
        .is_imm     (c_imm),
        .is_indexed (c_indexed),
        .is_dword   (c_dword),
        .kind_ok    (c_kind_ok)
    );

    ldc_fault u_fault (
        .ind_bit (instr[IND_BIT]),
        .is_imm  (c_imm),
        .kind_ok (c_kind_ok),
        .exists  (tbl_exists),
        .priv    (tbl_priv),
        .slave   (slave_mode),
        .fault   (c_fault)
    );

    ldc_addr #(.ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT)) u_addr (
        .ref_addr   (instr[ADDR_W-1:0]),
        .is_dword   (c_dword),
        .is_indexed (c_indexed),
        .eff_addr   (c_eff),
        .reg_sel    (c_rsel)
    );

    dec_state_e        state_q, state_d;
    logic [6:0]        opc_q;
    logic              ind_q, idx_q, rsel_q;
    size_e             size_q;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        state_d = ST_IDLE;
        if (in_valid) state_d = c_fault ? ST_TRAP : ST_ISSUE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            opc_q   <= '0;
            ind_q   <= 1'b0;
            idx_q   <= 1'b0;
            rsel_q  <= 1'b0;
            size_q  <= SZ_BYTE;
            addr_q  <= '0;
        end else if (!stall) begin
            state_q <= state_d;
            if (in_valid) begin
                opc_q  <= instr[OPC_HI:OPC_LO];
                ind_q  <= c_indexed & instr[IND_BIT];
                idx_q  <= c_indexed & (|instr[IDX_HI:IDX_LO]);
                rsel_q <= c_rsel;
                size_q <= c_size;
                addr_q <= c_eff;
            end
        end
    end

    always_comb begin
        trap_valid  = 1'b0;
        issue_valid = 1'b0;
        trap_vector = '0;
        opcode      = '0;
        indirect_en = 1'b0;
        index_en    = 1'b0;
        size_code   = '0;
        eff_addr    = '0;
        reg_sel     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_TRAP: begin
                trap_valid  = 1'b1;
                trap_vector = VEC_W'(TRAP_VEC);
            end
            ST_ISSUE: begin
                issue_valid = 1'b1;
                opcode      = opc_q;
                indirect_en = ind_q;
                index_en    = idx_q;
                size_code   = size_q;
                eff_addr    = addr_q;
                reg_sel     = rsel_q;
            end
            default: ;
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !trap_valid && !issue_valid); // R1
    AST_IMM_IND_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !stall && (tbl_kind == 3'd4 || tbl_kind == 3'd5) && instr[IND_BIT])
        |=> trap_valid && !issue_valid && trap_vector == VEC_W'(TRAP_VEC)); // R5
    AST_IMM_NO_INDEX: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !stall && (tbl_kind == 3'd4 || tbl_kind == 3'd5)) |=> !index_en && !indirect_en); // R6
    AST_PRIV_SLAVE_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !stall && tbl_priv && slave_mode) |=> trap_valid); // R7
    AST_MISSING_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !stall && !tbl_exists) |=> trap_valid); // R8
    AST_DWORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        issue_valid && size_code == 2'd3 |-> !eff_addr[0]); // R10
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(trap_valid) && $stable(issue_valid) && $stable(eff_addr)); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !stall) |=> !trap_valid && !issue_valid); // R13
endmodule

// File: tb/tb_ldc_top.sv
`timescale 1ns/1ps
module tb_ldc_top;
    logic        clk = 1'b0;
    logic        rst, stall, in_valid, slave_mode, tbl_priv, tbl_exists;
    logic [31:0] instr;
    logic [2:0]  tbl_kind;
    logic        trap_valid, issue_valid, indirect_en, index_en, reg_sel;
    logic [6:0]  trap_vector, opcode;
    logic [1:0]  size_code;
    logic [16:0] eff_addr;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ldc_top dut (
        .clk(clk), .rst(rst), .stall(stall), .in_valid(in_valid), .instr(instr),
        .slave_mode(slave_mode), .tbl_kind(tbl_kind), .tbl_priv(tbl_priv),
        .tbl_exists(tbl_exists), .trap_valid(trap_valid), .trap_vector(trap_vector),
        .issue_valid(issue_valid), .opcode(opcode), .indirect_en(indirect_en),
        .index_en(index_en), .size_code(size_code), .eff_addr(eff_addr), .reg_sel(reg_sel)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic ind, input logic [6:0] opc, input logic [2:0] idx,
                         input logic [16:0] addr, input logic [2:0] kind,
                         input logic priv, input logic exists, input logic slave);
        @(negedge clk);
        instr      = {ind, opc, 4'h0, idx, addr};
        tbl_kind   = kind;
        tbl_priv   = priv;
        tbl_exists = exists;
        slave_mode = slave;
        in_valid   = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic expect_trap(input string req);
        check(req, "trap_valid", 32'(trap_valid), 32'd1);
        check(req, "trap_vector", 32'(trap_vector), 32'h40);
        check(req, "issue_valid", 32'(issue_valid), 32'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1; stall = 1'b0; in_valid = 1'b0; instr = '0;
        tbl_kind = '0; tbl_priv = 1'b0; tbl_exists = 1'b1; slave_mode = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "trap_valid in reset", 32'(trap_valid), 32'd0);
        check("R1", "issue_valid in reset", 32'(issue_valid), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "trap_vector after reset", 32'(trap_vector), 32'd0);
        check("R1", "issue_valid after reset", 32'(issue_valid), 32'd0);
    endtask

    task automatic t_indexed_issue;
        apply(1'b1, 7'h32, 3'd3, 17'h01234, 3'd0, 1'b0, 1'b1, 1'b0);
        check("R2", "issue_valid", 32'(issue_valid), 32'd1);
        check("R2", "opcode", 32'(opcode), 32'h32);
        check("R3", "byte size", 32'(size_code), 32'd0);
        check("R4", "indirect_en", 32'(indirect_en), 32'd1);
        check("R4", "index_en", 32'(index_en), 32'd1);
        check("R10", "byte addr kept", 32'(eff_addr), 32'h01234);
    endtask

    task automatic t_sizes;
        for (int k = 1; k <= 3; k++) begin
            apply(1'b0, 7'h10, 3'd0, 17'h00567, 3'(k), 1'b0, 1'b1, 1'b0);
            check("R3", "size code", 32'(size_code), 32'(k));
            check("R4", "index_en off", 32'(index_en), 32'd0);
            check("R4", "indirect_en off", 32'(indirect_en), 32'd0);
            check("R10", "eff_addr", 32'(eff_addr), (k == 3) ? 32'h00566 : 32'h00567);
        end
    endtask

    task automatic t_reg_block;
        apply(1'b0, 7'h11, 3'd0, 17'd15, 3'd2, 1'b0, 1'b1, 1'b0);
        check("R11", "reg_sel at 15", 32'(reg_sel), 32'd1);
        apply(1'b0, 7'h11, 3'd0, 17'd16, 3'd2, 1'b0, 1'b1, 1'b0);
        check("R11", "reg_sel at 16", 32'(reg_sel), 32'd0);
        apply(1'b0, 7'h11, 3'd0, 17'd3, 3'd4, 1'b0, 1'b1, 1'b0);
        check("R11", "reg_sel immediate", 32'(reg_sel), 32'd0);
    endtask

    task automatic t_imm_indirect;
        apply(1'b1, 7'h22, 3'd0, 17'h00010, 3'd4, 1'b0, 1'b1, 1'b0);
        expect_trap("R5");
        apply(1'b1, 7'h23, 3'd0, 17'h00010, 3'd5, 1'b0, 1'b1, 1'b0);
        expect_trap("R5");
    endtask

    task automatic t_imm_noindex;
        apply(1'b0, 7'h24, 3'd7, 17'h00100, 3'd5, 1'b0, 1'b1, 1'b0);
        check("R6", "issue_valid", 32'(issue_valid), 32'd1);
        check("R6", "index_en", 32'(index_en), 32'd0);
        check("R6", "indirect_en", 32'(indirect_en), 32'd0);
        check("R3", "immediate size", 32'(size_code), 32'd2);
    endtask

    task automatic t_priv;
        apply(1'b0, 7'h0E, 3'd0, 17'h00200, 3'd2, 1'b1, 1'b1, 1'b1);
        expect_trap("R7");
        apply(1'b0, 7'h0E, 3'd0, 17'h00200, 3'd2, 1'b1, 1'b1, 1'b0);
        check("R7", "master issue", 32'(issue_valid), 32'd1);
        check("R7", "master no trap", 32'(trap_valid), 32'd0);
    endtask

    task automatic t_missing;
        apply(1'b0, 7'h7F, 3'd0, 17'h00300, 3'd2, 1'b0, 1'b0, 1'b0);
        expect_trap("R8");
        apply(1'b0, 7'h7E, 3'd0, 17'h00300, 3'd6, 1'b0, 1'b1, 1'b0);
        expect_trap("R8");
        apply(1'b0, 7'h7D, 3'd0, 17'h00300, 3'd7, 1'b0, 1'b1, 1'b0);
        expect_trap("R8");
    endtask

    task automatic t_multi;
        apply(1'b1, 7'h05, 3'd5, 17'h00001, 3'd4, 1'b1, 1'b0, 1'b1);
        expect_trap("R9");
        check("R9", "index_en in trap", 32'(index_en), 32'd0);
        @(posedge clk);
        #1;
        check("R9", "single pulse", 32'(trap_valid), 32'd0);
        check("R13", "idle issue_valid", 32'(issue_valid), 32'd0);
    endtask

    task automatic t_stall;
        apply(1'b0, 7'h33, 3'd1, 17'h00444, 3'd1, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        stall = 1'b1;
        instr = {1'b1, 7'h01, 4'h0, 3'd0, 17'h00001};
        tbl_kind = 3'd4; tbl_exists = 1'b0; in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R12", "issue held", 32'(issue_valid), 32'd1);
        check("R12", "no trap", 32'(trap_valid), 32'd0);
        check("R12", "addr held", 32'(eff_addr), 32'h00444);
        check("R12", "opcode held", 32'(opcode), 32'h33);
        @(negedge clk);
        stall = 1'b0; in_valid = 1'b0; tbl_exists = 1'b1;
        @(posedge clk);
        #1;
        check("R13", "idle after stall", 32'(issue_valid), 32'd0);
        check("R13", "idle trap", 32'(trap_valid), 32'd0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_indexed_issue();
        t_sizes();
        t_reg_block();
        t_imm_indirect();
        t_imm_noindex();
        t_priv();
        t_missing();
        t_multi();
        t_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule